// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block converts a segment-relative memory reference into a 20-bit physical address. It keeps four 16-bit segment bases: extra, code, stack and data. For each request it takes an access kind, an optional segment override and up to three offset terms: base, index and displacement. It adds the enabled terms into a 16-bit offset and chooses a segment. It then shifts that segment left by four bits and adds the offset to it.

The result is registered. The address, the number of the chosen segment and a valid strobe appear one clock after the request. Segment bases are loaded through a simple write port. The block sits between an address-mode decoder and a bus interface.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the code segment holds FFFF and the extra, stack and data segments hold 0000. `pa_valid` is low.
- R2: When `req_valid` is high at a clock edge, `pa_valid` is high after that edge. `pa_addr` equals (segment × 16 + zero-extended offset) and `pa_seg` gives the segment used.
- R3: The offset is the sum of `base_val`, `idx_val` and `disp_val`. A term whose enable is low adds zero. The sum wraps modulo 65536.
- R4: A fetch request (`req_kind` = 1) always uses the code segment (`pa_seg` = 1), whatever the override inputs hold.
- R5: A stack request (`req_kind` = 2) always uses the stack segment (`pa_seg` = 2), whatever the override inputs hold.
- R6: A data request (`req_kind` 0 or 3) uses the data segment (`pa_seg` = 3) when `ovr_en` is low. When `ovr_en` is high it uses the segment that `ovr_sel` names.
- R7: The physical-address sum wraps modulo 2^20. For example, segment FFFF with offset 0010 gives 00000.
- R8: Segment codes are 0 = extra, 1 = code, 2 = stack, 3 = data. A write loads the segment that `seg_wr_sel` names. A request issued in the same cycle as the write sees the old value, and requests from the next cycle on see the new value.
- R9: In a cycle without a request, `pa_valid` goes low after the edge, and `pa_addr` and `pa_seg` keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment write enable |
| seg_wr_sel | input | 2 | Segment to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_data | input | 16 | New segment base |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | 0 data, 1 fetch, 2 stack, 3 data |
| ovr_en | input | 1 | Segment override enable (data requests only) |
| ovr_sel | input | 2 | Override segment code |
| base_en | input | 1 | Include base term |
| base_val | input | 16 | Base term |
| idx_en | input | 1 | Include index term |
| idx_val | input | 16 | Index term |
| disp_en | input | 1 | Include displacement term |
| disp_val | input | 16 | Displacement term |
| pa_valid | output | 1 | Result valid, one cycle after request |
| pa_addr | output | 20 | Physical address |
| pa_seg | output | 2 | Segment code used |

## Verification
The assertions assume that the request inputs hold their values for the whole cycle in which `req_valid` is high. They recompute the offset's low nibble and the expected segment code from the inputs sampled at the request edge. They take every `req_kind` and `ovr_sel` code as legal, so no input combination falls outside them. The stimulus changes inputs only on falling edges. It drives arbitrary values onto the ignored inputs during idle cycles and onto the override inputs of fetch and stack requests, and each such case is covered by R4, R5 or R9.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seg_wr_en,
  input  logic [1:0]                 seg_wr_sel,
  input  logic [OFS_W-1:0]           seg_wr_data,
  input  logic                       req_valid,
  input  logic [1:0]                 req_kind,
  input  logic                       ovr_en,
  input  logic [1:0]                 ovr_sel,
  input  logic                       base_en,
  input  logic [OFS_W-1:0]           base_val,
  input  logic                       idx_en,
  input  logic [OFS_W-1:0]           idx_val,
  input  logic                       disp_en,
  input  logic [OFS_W-1:0]           disp_val,
  output logic                       pa_valid,
  output logic [OFS_W+SEG_SHIFT-1:0] pa_addr,
  output logic [1:0]                 pa_seg
);
  localparam int PA_W = OFS_W + SEG_SHIFT;
  localparam int NSEG = 4;
  localparam logic [1:0] S_EXTRA = 2'd0, S_CODE = 2'd1, S_STACK = 2'd2, S_DATA = 2'd3;
  localparam logic [1:0] K_FETCH = 2'd1, K_STACK = 2'd2;

  logic [OFS_W-1:0] seg_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [OFS_W-1:0] RST_V = (g == int'(S_CODE)) ? '1 : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  seg_q[g] <= RST_V;
      else if (seg_wr_en && seg_wr_sel == 2'(g))   seg_q[g] <= seg_wr_data;
    end
  end

  logic [OFS_W-1:0] t_base, t_idx, t_disp, offset;
  assign t_base = base_en ? base_val : '0;
  assign t_idx  = idx_en  ? idx_val  : '0;
  assign t_disp = disp_en ? disp_val : '0;
  assign offset = t_base + t_idx + t_disp;

  logic [1:0] seg_pick;
  always_comb begin
    case (req_kind)
      K_FETCH: seg_pick = S_CODE;
      K_STACK: seg_pick = S_STACK;
      default: seg_pick = ovr_en ? ovr_sel : S_DATA;
    endcase
  end

  logic [PA_W-1:0] seg_wide, ofs_wide, phys;
  assign seg_wide = {seg_q[seg_pick], {SEG_SHIFT{1'b0}}};
  assign ofs_wide = {{SEG_SHIFT{1'b0}}, offset};
  assign phys     = seg_wide + ofs_wide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_valid <= 1'b0;
      pa_addr  <= '0;
      pa_seg   <= S_EXTRA;
    end else begin
      pa_valid <= req_valid;
      if (req_valid) begin
        pa_addr <= phys;
        pa_seg  <= seg_pick;
      end
    end
  end
endmodule

module seg_addr_gen_chk #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [1:0]                 req_kind,
  input logic                       ovr_en,
  input logic [1:0]                 ovr_sel,
  input logic                       base_en,
  input logic [OFS_W-1:0]           base_val,
  input logic                       idx_en,
  input logic [OFS_W-1:0]           idx_val,
  input logic                       disp_en,
  input logic [OFS_W-1:0]           disp_val,
  input logic                       pa_valid,
  input logic [OFS_W+SEG_SHIFT-1:0] pa_addr,
  input logic [1:0]                 pa_seg
);
  logic [3:0] low_sum;
  assign low_sum = (base_en ? base_val[3:0] : 4'd0) + (idx_en ? idx_val[3:0] : 4'd0)
                 + (disp_en ? disp_val[3:0] : 4'd0);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pa_valid);
  p_low_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pa_addr[3:0] == $past(low_sum));
  p_fetch_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1) |=> pa_seg == 2'd1);
  p_stack_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2) |=> pa_seg == 2'd2);
  p_data_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[0] == req_kind[1] && !ovr_en) |=> pa_seg == 2'd3);
  p_data_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[0] == req_kind[1] && ovr_en) |=> pa_seg == $past(ovr_sel));
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !pa_valid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && $past(rst_n)) |=> ($stable(pa_addr) && $stable(pa_seg)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .ovr_en(ovr_en), .ovr_sel(ovr_sel), .base_en(base_en), .base_val(base_val),
  .idx_en(idx_en), .idx_val(idx_val), .disp_en(disp_en), .disp_val(disp_val),
  .pa_valid(pa_valid), .pa_addr(pa_addr), .pa_seg(pa_seg));

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seg_wr_en = 1'b0;
  logic [1:0] seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic ovr_en = 1'b0;
  logic [1:0] ovr_sel = '0;
  logic base_en = 1'b0, idx_en = 1'b0, disp_en = 1'b0;
  logic [15:0] base_val = '0, idx_val = '0, disp_val = '0;
  logic pa_valid;
  logic [19:0] pa_addr;
  logic [1:0] pa_seg;

  always #5 clk = ~clk;

  seg_addr_gen dut (.*);

  int checks = 0, errors = 0;
  logic [15:0] model [4];
  logic [19:0] exp_a_q [$];
  logic [1:0]  exp_s_q [$];
  string       tag_q [$];
  logic [19:0] last_a = '0;
  logic [1:0]  last_s = '0;
  bit seen = 0;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic req(input [1:0] kind, input bit oe, input [1:0] os,
                     input bit be, input [15:0] b, input bit ie, input [15:0] i,
                     input bit de, input [15:0] d, input string tag);
    logic [15:0] off;
    logic [1:0] s;
    off = (be ? b : 16'h0) + (ie ? i : 16'h0) + (de ? d : 16'h0);
    if (kind == 2'd1) s = 2'd1;
    else if (kind == 2'd2) s = 2'd2;
    else s = oe ? os : 2'd3;
    exp_a_q.push_back(20'({model[s], 4'h0} + {4'h0, off}));
    exp_s_q.push_back(s);
    tag_q.push_back(tag);
    req_valid = 1; req_kind = kind; ovr_en = oe; ovr_sel = os;
    base_en = be; base_val = b; idx_en = ie; idx_val = i; disp_en = de; disp_val = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr(input [1:0] sel, input [15:0] v);
    seg_wr_en = 1; seg_wr_sel = sel; seg_wr_data = v;
    @(negedge clk);
    seg_wr_en = 0;
    model[sel] = v;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pa_valid) begin
      if (exp_a_q.size() == 0) check(0, "R2", "valid without request");
      else begin
        logic [19:0] ea; logic [1:0] es; string t;
        ea = exp_a_q.pop_front(); es = exp_s_q.pop_front(); t = tag_q.pop_front();
        check(pa_addr == ea, t, $sformatf("addr act=%05h exp=%05h", pa_addr, ea));
        check(pa_seg == es, t, $sformatf("seg act=%0d exp=%0d", pa_seg, es));
      end
      last_a = pa_addr; last_s = pa_seg; seen = 1;
    end else if (seen) begin
      check(pa_addr == last_a && pa_seg == last_s, "R9",
            $sformatf("hold act=%05h/%0d exp=%05h/%0d", pa_addr, pa_seg, last_a, last_s));
    end
  end

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model[0] = 16'h0; model[1] = 16'hFFFF; model[2] = 16'h0; model[3] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pa_valid == 0, "R1", $sformatf("pa_valid act=%0d exp=0", pa_valid));
    // R1: reset bases seen through requests
    req(2'd1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    req(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    req(2'd2, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    req(2'd0, 1, 2'd0, 0, 0, 0, 0, 0, 0, "R1");
    @(negedge clk);
    // R8: loading each base
    wr(2'd3, 16'h1234); wr(2'd2, 16'h2000); wr(2'd0, 16'hB800); wr(2'd1, 16'h0100);
    // R2 / R3: offset term combinations
    req(2'd0, 0, 0, 1, 16'h0010, 0, 16'h5555, 0, 16'h7777, "R3");
    req(2'd0, 0, 0, 1, 16'h0010, 1, 16'h0020, 0, 16'h7777, "R3");
    req(2'd0, 0, 0, 1, 16'h0010, 1, 16'h0020, 1, 16'h0003, "R2");
    req(2'd0, 0, 0, 0, 16'h0010, 1, 16'h0020, 1, 16'h0003, "R3");
    req(2'd0, 0, 0, 1, 16'hFFFF, 0, 0, 1, 16'h0002, "R3");
    req(2'd0, 0, 0, 1, 16'h8000, 1, 16'h8000, 1, 16'h8000, "R3");
    // R4 / R5: override ignored
    req(2'd1, 1, 2'd0, 1, 16'h0044, 0, 0, 0, 0, "R4");
    req(2'd1, 1, 2'd3, 0, 0, 0, 0, 1, 16'hABCD, "R4");
    req(2'd2, 1, 2'd0, 1, 16'hFFFE, 0, 0, 0, 0, "R5");
    req(2'd2, 1, 2'd1, 0, 0, 1, 16'h0012, 0, 0, "R5");
    // R6: data defaults and overrides
    for (int k = 0; k < 4; k++)
      req(2'd0, 1, 2'(k), 0, 0, 0, 0, 1, 16'h0101, "R6");
    req(2'd3, 0, 2'd0, 1, 16'h0008, 0, 0, 0, 0, "R6");
    req(2'd3, 1, 2'd2, 1, 16'h0008, 0, 0, 0, 0, "R6");
    // R9: idle cycles with changing junk inputs
    for (int k = 0; k < 4; k++) begin
      req_kind = 2'(k); ovr_en = 1; ovr_sel = 2'(3 - k);
      base_en = 1; base_val = 16'(k * 16'h1111); disp_en = 1; disp_val = 16'hF0F0;
      @(negedge clk);
      check(pa_valid == 0, "R9", $sformatf("pa_valid act=%0d exp=0", pa_valid));
    end
    // R7: wrap at 2^20
    wr(2'd3, 16'hFFFF);
    req(2'd0, 0, 0, 0, 0, 0, 0, 1, 16'h0010, "R7");
    req(2'd0, 0, 0, 1, 16'hFFFF, 0, 0, 0, 0, "R7");
    req(2'd0, 0, 0, 0, 0, 0, 0, 1, 16'h000F, "R7");
    // R8: same-cycle write sees old value; next cycle sees new
    seg_wr_en = 1; seg_wr_sel = 2'd2; seg_wr_data = 16'h3000;
    req(2'd2, 0, 0, 1, 16'h0004, 0, 0, 0, 0, "R8");
    seg_wr_en = 0; model[2] = 16'h3000;
    req(2'd2, 0, 0, 1, 16'h0004, 0, 0, 0, 0, "R8");
    seg_wr_en = 1; seg_wr_sel = 2'd1; seg_wr_data = 16'h4321;
    req(2'd1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    seg_wr_en = 0; model[1] = 16'h4321;
    req(2'd1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    repeat (4) @(negedge clk);
    check(exp_a_q.size() == 0, "R2", $sformatf("pending act=%0d exp=0", exp_a_q.size()));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule